// File: doc/BRIEF.md
# Parity-Guarded Byte RAM

This block is a single-port byte memory that keeps one parity bit next to every stored byte. A write computes even parity over the byte and stores it with the data. A read returns the byte one cycle later, and in that same cycle the block recomputes parity over the returned byte and compares it with the stored bit. A mismatch pulses `par_err`, sets a sticky error flag in a small control register, and raises `rst_req` unless reset requests are masked. The system reset controller acts on `rst_req`. The parity column is not initialised at power-up, so software must write every location before reading it. A test input, `inj_par_flip`, stores the inverted parity bit on a write so that faults can be planted on purpose.

The control register has two live bits. Bit 7 is the reset mask (1 = no reset request). Bit 0 is the error flag, which only software can clear, by writing 0 to it. Bits 6 to 1 always read as zero. Software can write the register as a whole byte (`reg_wr`) or one bit at a time (`reg_bit_wr`). The error flag is kept as a three-state machine. `ST_CLEAN` means there is no error. `ST_MASKED` means an error is latched while requests are masked. `ST_REQUEST` means an error is latched and a reset is requested. The transitions are:

- `detect`: CLEAN to MASKED or REQUEST, depending on the next mask value.
- `unmask`: MASKED to REQUEST.
- `mask`: REQUEST to MASKED.
- `clear`: MASKED or REQUEST back to CLEAN, taken when software writes 0 to the flag and no error is detected in that cycle.

Top module: `parity_ram_guard`

## Requirements
- R1: A read issued with `mem_en`=1 and `mem_we`=0 presents the last byte written to that address on `mem_rdata` in the following cycle.
- R2: When a location was written with `inj_par_flip`=0, reading it leaves `par_err` at 0 and does not change the register.
- R3: Reading a location written with `inj_par_flip`=1 drives `par_err` to 1 in the cycle the read data is valid, and the error flag (register bit 0) reads 1 from the next cycle on.
- R4: A parity mismatch sets the error flag whatever the value of the mask bit (register bit 7).
- R5: Once the error flag is set, it stays 1 through later error-free reads and through writes that leave bit 0 at 1.
- R6: Writing 0 to bit 0 clears the error flag. Writing 1 to bit 0 leaves the flag unchanged.
- R7: When a mismatch is detected in the same cycle as a software clear of the flag, the flag ends up set.
- R8: After reset the register reads 0x00 and `rst_req` is 0. Bits 6 to 1 read 0 even after a write of 0xFF.
- R9: `rst_req` is a registered level that equals (flag AND NOT mask). Clearing the mask while the flag is set raises `rst_req` in the next cycle, and `rst_req` stays high until the flag is cleared or the mask is set.
- R10: A single-bit write (`reg_bit_wr`=1) loads `reg_wdata[0]` into the bit chosen by `reg_bit_sel`: 7 selects the mask and 0 selects the flag. Any other selection changes nothing. A byte write takes precedence over a bit write.
- R11: Rewriting a faulty location with `inj_par_flip`=0 makes later reads of it error-free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_en | input | 1 | Memory access enable |
| mem_we | input | 1 | 1 = write, 0 = read |
| mem_addr | input | ADDR_W | Byte address |
| mem_wdata | input | 8 | Write data |
| inj_par_flip | input | 1 | Test: store the inverted parity on this write |
| mem_rdata | output | 8 | Read data, valid in the cycle after the read |
| par_err | output | 1 | Parity mismatch on the current read data |
| reg_wr | input | 1 | Byte write to the control register |
| reg_bit_wr | input | 1 | Single-bit write to the control register |
| reg_bit_sel | input | 3 | Bit index for a single-bit write |
| reg_wdata | input | 8 | Register write data; bit 0 is the value for bit writes |
| reg_rdata | output | 8 | Control register contents |
| rst_req | output | 1 | Registered reset request level |

## Verification
The bench builds the block with `ADDR_W`=4, giving 16 locations. That size lets it fill the whole memory before any read, so no read ever touches an uninitialised parity bit, and it can then plant a fault at one address while its neighbours stay clean. The data patterns cover both even and odd bit counts, so the check is exercised against both stored parity values. Every transition of the flag state machine is reached, including a detection that coincides with a software clear.

// File: rtl/par_ram_pkg.sv
package par_ram_pkg;
    localparam int BYTE_W    = 8;
    localparam int SEL_W     = $clog2(BYTE_W);
    localparam int MASK_POS  = 7;
    localparam int FLAG_POS  = 0;

    typedef enum logic [1:0] {
        ST_CLEAN   = 2'd0,
        ST_MASKED  = 2'd1,
        ST_REQUEST = 2'd2
    } guard_state_t;

    function automatic logic even_par(input logic [BYTE_W-1:0] d);
        return ^d;
    endfunction
endpackage

// File: rtl/par_ram_array.sv
module par_ram_array
    import par_ram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              flip,
    output logic [BYTE_W-1:0] rdata,
    output logic              rpar,
    output logic              rvalid
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W:0] cells [DEPTH];
    logic [BYTE_W:0] dout_q;

    always_ff @(posedge clk) begin
        if (en && we) begin
            cells[addr] <= {even_par(wdata) ^ flip, wdata};
        end
        if (en && !we) begin
            dout_q <= cells[addr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
        end else begin
            rvalid <= en && !we;
        end
    end

    assign rdata = dout_q[BYTE_W-1:0];
    assign rpar  = dout_q[BYTE_W];
endmodule

// File: rtl/par_ram_verify.sv
module par_ram_verify
    import par_ram_pkg::*;
(
    input  logic              rvalid,
    input  logic [BYTE_W-1:0] rdata,
    input  logic              rpar,
    output logic              mismatch
);
    assign mismatch = rvalid && (even_par(rdata) != rpar);
endmodule

// File: rtl/par_ram_ctl.sv
module par_ram_ctl
    import par_ram_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_err,
    input  logic              reg_wr,
    input  logic              reg_bit_wr,
    input  logic [SEL_W-1:0]  reg_bit_sel,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              rst_req
);
    guard_state_t state_q, state_d;
    logic mask_q, mask_d;
    logic sw_clr;
    logic flag_q, flag_d;
    logic unused_wdata;

    assign unused_wdata = ^reg_wdata[BYTE_W-2:1];

    // software write decode
    always_comb begin
        mask_d = mask_q;
        sw_clr = 1'b0;
        if (reg_wr) begin
            mask_d = reg_wdata[MASK_POS];
            sw_clr = !reg_wdata[FLAG_POS];
        end else if (reg_bit_wr) begin
            if (reg_bit_sel == SEL_W'(MASK_POS)) begin
                mask_d = reg_wdata[0];
            end else if (reg_bit_sel == SEL_W'(FLAG_POS)) begin
                sw_clr = !reg_wdata[0];
            end
        end
    end

    assign flag_q = (state_q != ST_CLEAN);
    assign flag_d = hw_err || (flag_q && !sw_clr);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAN: begin
                if (hw_err) begin
                    state_d = mask_d ? ST_MASKED : ST_REQUEST;       // detect
                end
            end
            ST_MASKED: begin
                if (!flag_d) begin
                    state_d = ST_CLEAN;                              // clear
                end else if (!mask_d) begin
                    state_d = ST_REQUEST;                            // unmask
                end
            end
            ST_REQUEST: begin
                if (!flag_d) begin
                    state_d = ST_CLEAN;                              // clear
                end else if (mask_d) begin
                    state_d = ST_MASKED;                             // mask
                end
            end
            default: state_d = ST_CLEAN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLEAN;
            mask_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            mask_q  <= mask_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
        end else begin
            rst_req <= (state_d == ST_REQUEST);
        end
    end

    always_comb begin
        reg_rdata           = '0;
        reg_rdata[MASK_POS] = mask_q;
        reg_rdata[FLAG_POS] = flag_q;
    end
endmodule

// File: rtl/parity_ram_guard.sv
module parity_ram_guard
    import par_ram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_en,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_wdata,
    input  logic              inj_par_flip,
    output logic [7:0]        mem_rdata,
    output logic              par_err,
    input  logic              reg_wr,
    input  logic              reg_bit_wr,
    input  logic [2:0]        reg_bit_sel,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              rst_req
);
    logic rd_par;
    logic rd_valid;

    par_ram_array #(.ADDR_W(ADDR_W)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (mem_en),
        .we     (mem_we),
        .addr   (mem_addr),
        .wdata  (mem_wdata),
        .flip   (inj_par_flip),
        .rdata  (mem_rdata),
        .rpar   (rd_par),
        .rvalid (rd_valid)
    );

    par_ram_verify u_verify (
        .rvalid   (rd_valid),
        .rdata    (mem_rdata),
        .rpar     (rd_par),
        .mismatch (par_err)
    );

    par_ram_ctl u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .hw_err      (par_err),
        .reg_wr      (reg_wr),
        .reg_bit_wr  (reg_bit_wr),
        .reg_bit_sel (reg_bit_sel),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .rst_req     (rst_req)
    );
endmodule

// File: rtl/parity_ram_guard_sva.sv
module parity_ram_guard_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       mem_en,
    input logic       mem_we,
    input logic       par_err,
    input logic       reg_wr,
    input logic       reg_bit_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       rst_req
);
    AST_UNUSED_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[6:1] == 6'd0);                                          // R8
    AST_REQ_TRACKS_REG: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req == (reg_rdata[0] && !reg_rdata[7]));                      // R9
    AST_ERR_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |=> reg_rdata[0]);                                        // R3
    AST_ERR_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> $past(mem_en && !mem_we));                            // R3
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[0] && !reg_wr && !reg_bit_wr) |=> reg_rdata[0]);       // R5
    AST_ONE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[0] && !reg_rdata[0] && !par_err) |=> !reg_rdata[0]); // R6
endmodule

bind parity_ram_guard parity_ram_guard_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .par_err    (par_err),
    .reg_wr     (reg_wr),
    .reg_bit_wr (reg_bit_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .rst_req    (rst_req)
);

// File: tb/parity_ram_guard_bench.sv
module parity_ram_guard_bench;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mem_en = 1'b0, mem_we = 1'b0, inj_par_flip = 1'b0;
    logic [AW-1:0] mem_addr = '0;
    logic [7:0]    mem_wdata = '0;
    logic [7:0]    mem_rdata;
    logic          par_err;
    logic          reg_wr = 1'b0, reg_bit_wr = 1'b0;
    logic [2:0]    reg_bit_sel = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          rst_req;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] model [16];

    always #4 clk = ~clk;

    parity_ram_guard #(.ADDR_W(AW)) u_parity_ram_guard (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic mwr(input int a, input logic [7:0] d, input logic flip);
        mem_en = 1'b1; mem_we = 1'b1; mem_addr = AW'(a); mem_wdata = d; inj_par_flip = flip;
        cyc();
        mem_en = 1'b0; mem_we = 1'b0; inj_par_flip = 1'b0;
        model[a] = d;
    endtask

    // leaves the bench in the cycle the read data is valid
    task automatic mrd(input int a);
        mem_en = 1'b1; mem_we = 1'b0; mem_addr = AW'(a);
        cyc();
        mem_en = 1'b0;
    endtask

    task automatic rwr(input logic [7:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic rbit(input int sel, input logic v);
        reg_bit_wr = 1'b1; reg_bit_sel = 3'(sel); reg_wdata = {7'd0, v};
        cyc();
        reg_bit_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R8 reset reg", reg_rdata, 8'h00);
        chk("R8 reset req", {7'd0, rst_req}, 8'h00);
    endtask

    task automatic t_fill_and_read();
        for (int i = 0; i < 16; i++) mwr(i, 8'(i * 37 + 5), 1'b0);
        mwr(3, 8'h00, 1'b0);
        mwr(4, 8'hFF, 1'b0);
        mwr(6, 8'h01, 1'b0);
        mwr(7, 8'h7F, 1'b0);
        for (int i = 0; i < 16; i++) begin
            mrd(i);
            chk("R1 readback", mem_rdata, model[i]);
            chk("R2 clean read err", {7'd0, par_err}, 8'h00);
        end
        cyc();
        chk("R2 reg untouched", reg_rdata, 8'h00);
    endtask

    task automatic t_inject_unmasked();
        mwr(5, 8'hA6, 1'b1);
        mrd(5);
        chk("R3 err pulse", {7'd0, par_err}, 8'h01);
        chk("R1 data on bad parity", mem_rdata, 8'hA6);
        cyc();
        chk("R3 flag set", reg_rdata, 8'h01);
        chk("R9 req on error", {7'd0, rst_req}, 8'h01);
        chk("R3 err pulse ends", {7'd0, par_err}, 8'h00);
        rwr(8'h00);
        chk("R6 clear by zero", reg_rdata, 8'h00);
        chk("R9 req drops on clear", {7'd0, rst_req}, 8'h00);
    endtask

    task automatic t_masked_sticky();
        rwr(8'h80);
        mrd(5);
        cyc();
        chk("R4 flag under mask", reg_rdata, 8'h81);
        chk("R9 no req when masked", {7'd0, rst_req}, 8'h00);
        mrd(2);
        mrd(9);
        cyc();
        chk("R5 sticky after clean reads", reg_rdata, 8'h81);
        rwr(8'h81);
        chk("R5 R6 write one keeps flag", reg_rdata, 8'h81);
        rbit(3, 1'b1);
        chk("R10 other bit ignored", reg_rdata, 8'h81);
        rbit(7, 1'b0);
        chk("R10 bit write mask", reg_rdata, 8'h01);
        chk("R9 unmask pending raises req", {7'd0, rst_req}, 8'h01);
        cyc();
        chk("R9 req held", {7'd0, rst_req}, 8'h01);
        rbit(7, 1'b1);
        chk("R9 req drops on mask", {7'd0, rst_req}, 8'h00);
        rbit(0, 1'b0);
        chk("R10 bit write clears flag", reg_rdata, 8'h80);
    endtask

    task automatic t_write_ones();
        rwr(8'h00);
        rwr(8'hFF);
        chk("R8 R6 write FF", reg_rdata, 8'h80);
        chk("R6 no req from write one", {7'd0, rst_req}, 8'h00);
    endtask

    task automatic t_priority();
        rwr(8'h81);
        mrd(5);
        reg_wr = 1'b1; reg_wdata = 8'h80;
        cyc();
        reg_wr = 1'b0;
        chk("R7 set wins over clear", reg_rdata, 8'h81);
        reg_wr = 1'b1; reg_bit_wr = 1'b1; reg_bit_sel = 3'd7; reg_wdata = 8'h00;
        cyc();
        reg_wr = 1'b0; reg_bit_wr = 1'b0;
        chk("R10 byte beats bit write", reg_rdata, 8'h00);
    endtask

    task automatic t_repair();
        mwr(5, 8'h3C, 1'b0);
        mrd(5);
        chk("R11 repaired read err", {7'd0, par_err}, 8'h00);
        chk("R11 repaired data", mem_rdata, 8'h3C);
        cyc();
        chk("R11 flag stays clear", reg_rdata, 8'h00);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_fill_and_read();
        t_inject_unmasked();
        t_masked_sticky();
        t_write_ones();
        t_priority();
        t_repair();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule